// File: doc/BRIEF.md
# Test-Mode Memory Dump Sequencer

This block runs a diagnostic mode in which the chip sends a copy of its configuration memory out through one pin, one byte at a time. It watches a digitised flag that reports whether the test voltage is present on that pin. It also watches a 2-bit mode code and a memory-select bit. When the flag is high and bit 0 of the mode code is set, the block picks a source memory and an address window. It then walks that window without end. For each address it issues a read request, waits for the data, and hands the byte to the line serializer. It moves to the next address only after the serializer reports that the byte and its trailing pause are complete.

When the flag drops, the dump stops at once. The block tells the serializer to return to idle. One cycle later it may pulse a request that makes the chip read its configuration again. Whether that request is made depends on the mode code present at the moment of exit. An elaboration parameter selects whether the reload covers the shortened range (up to 0x21) or the whole nonvolatile memory. The comparators, the memories and the line encoder sit outside this block.

Top module: `tm_dump_seq`

## Requirements
- R1: The dump starts only when `tv_hi` is 1 and `mode_code[0]` is 1 at a clock edge while the block is idle. `dump_active` goes high on the following cycle. With mode codes 00 and 10, or with `tv_hi` low, the block stays idle and issues no reads.
- R2: Mode code 01 with `mem_sel` = 0 walks addresses 0x1B to 0x7F in the nonvolatile memory (`rd_src` = 0).
- R3: Mode code 01 with `mem_sel` = 1 walks addresses 0x3B to 0x43 in working RAM (`rd_src` = 1).
- R4: Mode code 11 walks addresses 0x00 to 0x7F in the nonvolatile memory (`rd_src` = 0), whatever the value of `mem_sel`.
- R5: For each address, `rd_req` stays high until a cycle in which `rd_valid` is sampled high. In the next cycle `ser_load` is high for exactly one cycle, and `ser_byte` carries the captured `rd_data`.
- R6: The address moves on only when `ser_done` arrives after that byte's load. After the last address of the window, the walk returns to the first address and continues.
- R7: While the dump is active, `tv_hi` = 0 raises `ser_abort` in the same cycle and suppresses `rd_req` and `ser_load`. The block is idle from the next cycle on.
- R8: One cycle after such an abort, `reload_req` pulses for exactly one cycle if the mode code at the abort edge is not 00. It does not pulse if the mode code is 00. In the default (shortened) variant the pulse carries `reload_full` = 0 and `reload_end` = 0x21. In the full variant it carries `reload_full` = 1 and `reload_end` = 0x7F. Both fields are 0 outside the pulse.
- R9: The window and the source are fixed when the dump is entered. Changes to `mode_code` or `mem_sel` during the dump do not alter them.
- R10: After reset, `rd_req`, `ser_load`, `ser_abort`, `dump_active` and `reload_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tv_hi | input | 1 | Test voltage present on the error pin (digitised) |
| mode_code | input | 2 | Test mode code from configuration |
| mem_sel | input | 1 | Selects the source: 0 nonvolatile re-read, 1 working RAM |
| rd_req | output | 1 | Byte read request |
| rd_src | output | 1 | Memory addressed by the request: 0 nonvolatile, 1 RAM |
| rd_addr | output | AW (7) | Address of the requested byte |
| rd_valid | input | 1 | Read data present on `rd_data` |
| rd_data | input | DW (8) | Read data |
| ser_load | output | 1 | Hand `ser_byte` to the serializer |
| ser_byte | output | DW (8) | Byte to transmit |
| ser_done | input | 1 | Serializer has finished the byte and its pause |
| ser_abort | output | 1 | Return the serializer to idle at once |
| dump_active | output | 1 | Test dump in progress |
| reload_req | output | 1 | One-cycle request to reload the configuration |
| reload_full | output | 1 | With `reload_req`: 1 for a whole-memory reload |
| reload_end | output | AW (7) | With `reload_req`: last address of the reload range |

## Verification
On every cycle the bound checker checks the following:
- the block is quiet while idle, and entry follows whenever its conditions hold;
- an abort happens immediately and the block is idle on the next cycle;
- each reload pulse lasts one cycle and has a valid cause;
- every load follows an accepted read;
- the address holds until `ser_done` arrives;
- RAM reads stay inside their window;
- the source stays fixed during a dump.

Only the bench scenarios can show some behaviours:
- the exact address sequence of each window, including its wrap back to the first address;
- that `mem_sel` is ignored under mode code 11;
- that the window is unaffected by changes in the middle of a dump;
- that no reload follows an exit made with mode code 00.

// File: rtl/tm_dump_pkg.sv
package tm_dump_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_READ = 2'd1,
      ST_LOAD = 2'd2,
      ST_WAIT = 2'd3
   } tm_state_e;

   typedef enum logic {
      SRC_NVM = 1'b0,
      SRC_RAM = 1'b1
   } tm_src_e;

   localparam logic [1:0] MC_NORMAL_A = 2'b00;
   localparam logic [1:0] MC_PART     = 2'b01;
   localparam logic [1:0] MC_NORMAL_B = 2'b10;
   localparam logic [1:0] MC_FULL     = 2'b11;

endpackage

// File: rtl/tm_window_dec.sv
module tm_window_dec
   import tm_dump_pkg::*;
#(
   parameter int AW          = 7,
   parameter int NVM_PART_LO = 'h1B,
   parameter int NVM_HI      = 'h7F,
   parameter int RAM_LO      = 'h3B,
   parameter int RAM_HI      = 'h43,
   parameter int FULL_LO     = 'h00
) (
   input  logic [1:0]    mode_code,
   input  logic          mem_sel,
   output logic          win_ok,
   output logic [AW-1:0] win_lo,
   output logic [AW-1:0] win_hi,
   output tm_src_e       win_src
);

   localparam int ADDR_MAX = (1 << AW) - 1;
   localparam logic [AW-1:0] L_PART_LO = AW'(NVM_PART_LO);
   localparam logic [AW-1:0] L_NVM_HI  = AW'(NVM_HI);
   localparam logic [AW-1:0] L_RAM_LO  = AW'(RAM_LO);
   localparam logic [AW-1:0] L_RAM_HI  = AW'(RAM_HI);
   localparam logic [AW-1:0] L_FULL_LO = AW'(FULL_LO);

   // elaboration-time parameter checks
   if (AW < 1 || AW > 16) begin : g_bad_aw
      $error("tm_window_dec: AW out of range");
   end
   if (NVM_HI > ADDR_MAX || RAM_HI > ADDR_MAX) begin : g_bad_hi
      $error("tm_window_dec: window end exceeds address space");
   end
   if (NVM_PART_LO > NVM_HI || FULL_LO > NVM_HI || RAM_LO > RAM_HI) begin : g_bad_order
      $error("tm_window_dec: window start above window end");
   end

   always_comb begin
      win_ok  = mode_code[0];
      win_lo  = '0;
      win_hi  = '0;
      win_src = SRC_NVM;
      unique case (mode_code)
         MC_PART: begin
            if (mem_sel) begin
               win_lo  = L_RAM_LO;
               win_hi  = L_RAM_HI;
               win_src = SRC_RAM;
            end else begin
               win_lo  = L_PART_LO;
               win_hi  = L_NVM_HI;
               win_src = SRC_NVM;
            end
         end
         MC_FULL: begin
            win_lo  = L_FULL_LO;
            win_hi  = L_NVM_HI;
            win_src = SRC_NVM;
         end
         MC_NORMAL_A, MC_NORMAL_B: begin
            win_lo  = '0;
            win_hi  = '0;
            win_src = SRC_NVM;
         end
         default: begin
            win_lo  = '0;
            win_hi  = '0;
            win_src = SRC_NVM;
         end
      endcase
   end

endmodule

// File: rtl/tm_addr_walk.sv
module tm_addr_walk #(
   parameter int AW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] lo,
   input  logic [AW-1:0] hi,
   input  logic          step,
   output logic [AW-1:0] addr
);

   logic [AW-1:0] lo_q;
   logic [AW-1:0] hi_q;
   logic [AW-1:0] addr_q;
   logic          at_end;

   assign at_end = (addr_q == hi_q);
   assign addr   = addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q   <= '0;
         hi_q   <= '0;
         addr_q <= '0;
      end else if (load) begin
         lo_q   <= lo;
         hi_q   <= hi;
         addr_q <= lo;
      end else if (step) begin
         addr_q <= at_end ? lo_q : addr_q + AW'(1);
      end
   end

endmodule

// File: rtl/tm_reload_gen.sv
module tm_reload_gen #(
   parameter int AW           = 7,
   parameter bit SHORT_RELOAD = 1'b1,
   parameter int SHORT_END    = 'h21,
   parameter int FULL_END     = 'h7F
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          exit_evt,
   input  logic [1:0]    exit_code,
   output logic          reload_req,
   output logic          reload_full,
   output logic [AW-1:0] reload_end
);

   localparam int ADDR_MAX = (1 << AW) - 1;

   if (SHORT_END > ADDR_MAX || FULL_END > ADDR_MAX) begin : g_bad_end
      $error("tm_reload_gen: reload range exceeds address space");
   end

   logic          full_c;
   logic [AW-1:0] end_c;
   logic          req_q;

   if (SHORT_RELOAD) begin : g_short
      assign full_c = 1'b0;
      assign end_c  = AW'(SHORT_END);
   end else begin : g_full
      assign full_c = 1'b1;
      assign end_c  = AW'(FULL_END);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= exit_evt && (exit_code != 2'b00);
   end

   assign reload_req  = req_q;
   assign reload_full = req_q & full_c;
   assign reload_end  = req_q ? end_c : '0;

endmodule

// File: rtl/tm_dump_seq.sv
module tm_dump_seq
   import tm_dump_pkg::*;
#(
   parameter int AW           = 7,
   parameter int DW           = 8,
   parameter int NVM_PART_LO  = 'h1B,
   parameter int NVM_HI       = 'h7F,
   parameter int RAM_LO       = 'h3B,
   parameter int RAM_HI       = 'h43,
   parameter int FULL_LO      = 'h00,
   parameter int SHORT_END    = 'h21,
   parameter bit SHORT_RELOAD = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tv_hi,
   input  logic [1:0]    mode_code,
   input  logic          mem_sel,
   output logic          rd_req,
   output logic          rd_src,
   output logic [AW-1:0] rd_addr,
   input  logic          rd_valid,
   input  logic [DW-1:0] rd_data,
   output logic          ser_load,
   output logic [DW-1:0] ser_byte,
   input  logic          ser_done,
   output logic          ser_abort,
   output logic          dump_active,
   output logic          reload_req,
   output logic          reload_full,
   output logic [AW-1:0] reload_end
);

   if (DW < 1) begin : g_bad_dw
      $error("tm_dump_seq: DW must be positive");
   end

   tm_state_e     state_q;
   tm_src_e       src_q;
   logic [DW-1:0] byte_q;

   logic          win_ok;
   logic [AW-1:0] win_lo;
   logic [AW-1:0] win_hi;
   tm_src_e       win_src;

   logic          busy;
   logic          enter;
   logic          exit_evt;
   logic          step;

   tm_window_dec #(
      .AW(AW), .NVM_PART_LO(NVM_PART_LO), .NVM_HI(NVM_HI),
      .RAM_LO(RAM_LO), .RAM_HI(RAM_HI), .FULL_LO(FULL_LO)
   ) u_win (
      .mode_code (mode_code),
      .mem_sel   (mem_sel),
      .win_ok    (win_ok),
      .win_lo    (win_lo),
      .win_hi    (win_hi),
      .win_src   (win_src)
   );

   assign busy     = (state_q != ST_IDLE);
   assign enter    = !busy && tv_hi && win_ok;
   assign exit_evt = busy && !tv_hi;
   assign step     = (state_q == ST_WAIT) && tv_hi && ser_done;

   tm_addr_walk #(.AW(AW)) u_walk (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (enter),
      .lo    (win_lo),
      .hi    (win_hi),
      .step  (step),
      .addr  (rd_addr)
   );

   tm_reload_gen #(
      .AW(AW), .SHORT_RELOAD(SHORT_RELOAD),
      .SHORT_END(SHORT_END), .FULL_END(NVM_HI)
   ) u_reload (
      .clk         (clk),
      .rst_n       (rst_n),
      .exit_evt    (exit_evt),
      .exit_code   (mode_code),
      .reload_req  (reload_req),
      .reload_full (reload_full),
      .reload_end  (reload_end)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         src_q   <= SRC_NVM;
         byte_q  <= '0;
      end else if (enter) begin
         state_q <= ST_READ;
         src_q   <= win_src;
      end else if (exit_evt) begin
         state_q <= ST_IDLE;
      end else begin
         unique case (state_q)
            ST_READ: if (rd_valid) begin
               byte_q  <= rd_data;
               state_q <= ST_LOAD;
            end
            ST_LOAD: state_q <= ST_WAIT;
            ST_WAIT: if (ser_done) state_q <= ST_READ;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign rd_req      = (state_q == ST_READ) && tv_hi;
   assign rd_src      = src_q;
   assign ser_load    = (state_q == ST_LOAD) && tv_hi;
   assign ser_byte    = byte_q;
   assign ser_abort   = exit_evt;
   assign dump_active = busy;

endmodule

// File: rtl/tm_dump_seq_chk.sv
module tm_dump_seq_chk #(
   parameter int AW     = 7,
   parameter int RAM_LO = 'h3B,
   parameter int RAM_HI = 'h43
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tv_hi,
   input logic [1:0]    mode_code,
   input logic          dump_active,
   input logic          rd_req,
   input logic          rd_valid,
   input logic          rd_src,
   input logic [AW-1:0] rd_addr,
   input logic          ser_load,
   input logic          ser_done,
   input logic          ser_abort,
   input logic          reload_req
);

   // R1: an idle block issues no traffic
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !dump_active |-> (!rd_req && !ser_load && !ser_abort));

   // R1: entry conditions lead to an active dump
   p_enter_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!dump_active && tv_hi && mode_code[0]) |=> dump_active);

   // R7: abort is immediate and the block is idle afterwards
   p_abort_now_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dump_active && !tv_hi) |-> (ser_abort && !rd_req && !ser_load));

   p_abort_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dump_active && !tv_hi) |=> !dump_active);

   // R8: reload is a single-cycle pulse caused by an exit with a non-zero code
   p_reload_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      reload_req |=> !reload_req);

   p_reload_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      reload_req |-> ($past(dump_active && !tv_hi) && $past(mode_code) != 2'b00));

   // R5: a load follows an accepted read
   p_load_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ser_load |-> $past(rd_req && rd_valid));

   p_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_req, ser_load, ser_abort}));

   // R6: address only changes after the serializer finishes
   p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dump_active && $past(dump_active) && !$past(ser_done)) |-> $stable(rd_addr));

   // R3: RAM reads stay within the RAM window
   p_ram_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_src) |-> (rd_addr >= AW'(RAM_LO) && rd_addr <= AW'(RAM_HI)));

   // R9: source fixed for the duration of a dump
   p_src_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dump_active && $past(dump_active)) |-> $stable(rd_src));

endmodule

bind tm_dump_seq tm_dump_seq_chk #(.AW(AW), .RAM_LO(RAM_LO), .RAM_HI(RAM_HI)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tv_hi       (tv_hi),
   .mode_code   (mode_code),
   .dump_active (dump_active),
   .rd_req      (rd_req),
   .rd_valid    (rd_valid),
   .rd_src      (rd_src),
   .rd_addr     (rd_addr),
   .ser_load    (ser_load),
   .ser_done    (ser_done),
   .ser_abort   (ser_abort),
   .reload_req  (reload_req)
);

// File: tb/tm_dump_seq_tb.sv
`timescale 1ns/1ps
module tm_dump_seq_tb;
   localparam int AW = 7;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tv_hi = 1'b0;
   logic [1:0]    mode_code = 2'b00;
   logic          mem_sel = 1'b0;
   logic          rd_valid = 1'b0;
   logic [DW-1:0] rd_data = '0;
   logic          ser_done = 1'b0;
   logic          rd_req, rd_src, ser_load, ser_abort, dump_active, reload_req, reload_full;
   logic [AW-1:0] rd_addr, reload_end;
   logic [DW-1:0] ser_byte;

   tm_dump_seq u_dut (
      .clk(clk), .rst_n(rst_n), .tv_hi(tv_hi), .mode_code(mode_code), .mem_sel(mem_sel),
      .rd_req(rd_req), .rd_src(rd_src), .rd_addr(rd_addr), .rd_valid(rd_valid),
      .rd_data(rd_data), .ser_load(ser_load), .ser_byte(ser_byte), .ser_done(ser_done),
      .ser_abort(ser_abort), .dump_active(dump_active), .reload_req(reload_req),
      .reload_full(reload_full), .reload_end(reload_end)
   );

   always #4 clk = ~clk;

   int n_tests = 0;
   int n_fail  = 0;
   int ser_len = 3;
   int mem_lat = 0;
   int ser_cnt = 0;
   int rq_cnt  = 0;
   int rel_cnt = 0;
   logic [DW-1:0] got_q[$];

   // reference model state
   int            m_st = 0;
   logic [AW-1:0] m_addr = '0, m_lo = '0, m_hi = '0;
   logic          m_src = 1'b0;
   logic [DW-1:0] m_byte = '0;
   logic          m_rel = 1'b0;

   task automatic chk(input string what, input longint act, input longint exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   function automatic void window(input logic [1:0] mc, input logic ms,
                                  output logic [AW-1:0] lo, output logic [AW-1:0] hi,
                                  output logic src);
      if (mc == 2'b01 && ms) begin lo = 7'h3B; hi = 7'h43; src = 1'b1; end
      else if (mc == 2'b01)  begin lo = 7'h1B; hi = 7'h7F; src = 1'b0; end
      else                   begin lo = 7'h00; hi = 7'h7F; src = 1'b0; end
   endfunction

   // model update just after each rising edge, from inputs held across it
   initial forever begin
      @(posedge clk); #1;
      if (!rst_n) begin
         m_st = 0; m_rel = 1'b0;
      end else begin
         m_rel = (m_st != 0) && !tv_hi && (mode_code != 2'b00);
         if (m_st == 0) begin
            if (tv_hi && mode_code[0]) begin
               window(mode_code, mem_sel, m_lo, m_hi, m_src);
               m_addr = m_lo;
               m_st = 1;
            end
         end else if (!tv_hi) begin
            m_st = 0;
         end else if (m_st == 1) begin
            if (rd_valid) begin m_byte = rd_data; m_st = 2; end
         end else if (m_st == 2) begin
            m_st = 3;
         end else if (ser_done) begin
            m_addr = (m_addr == m_hi) ? m_lo : m_addr + 7'd1;
            m_st = 1;
         end
      end
   end

   // responders at falling edge + 1, comparison at falling edge + 3
   initial forever begin
      @(negedge clk); #1;
      rq_cnt   = rd_req ? rq_cnt + 1 : 0;
      rd_valid = rd_req && (rq_cnt > mem_lat);
      rd_data  = {rd_src, rd_addr};
      ser_done = 1'b0;
      if (ser_abort) ser_cnt = 0;
      else if (ser_load) ser_cnt = ser_len;
      else if (ser_cnt > 0) begin
         ser_cnt--;
         if (ser_cnt == 0) ser_done = 1'b1;
      end
      #2;
      if (rst_n) begin
         chk("R1 dump_active", dump_active, m_st != 0);
         chk("R5 rd_req", rd_req, (m_st == 1) && tv_hi);
         chk("R5 ser_load", ser_load, (m_st == 2) && tv_hi);
         chk("R7 ser_abort", ser_abort, (m_st != 0) && !tv_hi);
         chk("R8 reload_req", reload_req, m_rel);
         chk("R8 reload_full", reload_full, 0);
         chk("R8 reload_end", reload_end, m_rel ? 'h21 : 0);
         if (rd_req) begin
            chk("R6 rd_addr", rd_addr, m_addr);
            chk("R2 rd_src", rd_src, m_src);
         end
         if (ser_load) begin
            chk("R5 ser_byte", ser_byte, m_byte);
            got_q.push_back(ser_byte);
         end
         if (reload_req) rel_cnt++;
      end
   end

   task automatic set_in(input logic tv, input logic [1:0] mc, input logic ms);
      @(negedge clk); #2;
      tv_hi = tv; mode_code = mc; mem_sel = ms;
   endtask

   task automatic wait_bytes(input int n);
      while (got_q.size() < n) @(negedge clk);
   endtask

   task automatic check_seq(input string tag, input logic src, input int lo,
                            input int hi, input int n);
      int bad = -1;
      for (int i = 0; i < n; i++) begin
         logic [DW-1:0] e;
         e = {src, 7'(lo + (i % (hi - lo + 1)))};
         if (bad < 0 && got_q[i] != e) bad = i;
      end
      if (bad < 0) chk(tag, 0, 0);
      else chk({tag, " byte sequence"}, got_q[bad], {src, 7'(lo + (bad % (hi - lo + 1)))});
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #3;
      chk("R10 reset rd_req", rd_req, 0);
      chk("R10 reset ser_load", ser_load, 0);
      chk("R10 reset ser_abort", ser_abort, 0);
      chk("R10 reset dump_active", dump_active, 0);
      chk("R10 reset reload_req", reload_req, 0);
      @(negedge clk); #2 rst_n = 1'b1;

      // R1: codes 00 and 10, and code 01 without the voltage, stay idle
      set_in(1'b1, 2'b00, 1'b0); repeat (15) @(negedge clk);
      set_in(1'b1, 2'b10, 1'b1); repeat (15) @(negedge clk);
      set_in(1'b0, 2'b01, 1'b0); repeat (15) @(negedge clk);
      chk("R1 no bytes outside test mode", got_q.size(), 0);
      chk("R1 no reload outside test mode", rel_cnt, 0);

      // R2, R6: partial nonvolatile window with wrap, then abort R7/R8
      set_in(1'b1, 2'b01, 1'b0);
      wait_bytes(103);
      check_seq("R2 R6 partial window", 1'b0, 'h1B, 'h7F, 103);
      set_in(1'b0, 2'b01, 1'b0); #1;
      chk("R7 abort same cycle", ser_abort, 1);
      @(negedge clk); #3;
      chk("R7 idle next cycle", dump_active, 0);
      chk("R8 reload pulse", reload_req, 1);
      chk("R8 short reload end", reload_end, 'h21);
      repeat (5) @(negedge clk);
      chk("R8 single reload", rel_cnt, 1);

      // R3: RAM window, slow memory for R5
      got_q.delete(); rel_cnt = 0; mem_lat = 3;
      set_in(1'b1, 2'b01, 1'b1);
      wait_bytes(20);
      check_seq("R3 RAM window", 1'b1, 'h3B, 'h43, 20);
      set_in(1'b0, 2'b10, 1'b1); repeat (3) @(negedge clk);
      chk("R8 reload after code 10", rel_cnt, 1);

      // R4: full window, mem_sel ignored
      got_q.delete(); rel_cnt = 0; mem_lat = 0;
      set_in(1'b1, 2'b11, 1'b1);
      wait_bytes(131);
      check_seq("R4 full window", 1'b0, 'h00, 'h7F, 131);
      set_in(1'b0, 2'b11, 1'b1); repeat (3) @(negedge clk);

      // R9: changes during a dump have no effect; R6 with slow serializer;
      // R8: exit with code 00 requests no reload
      got_q.delete(); rel_cnt = 0; ser_len = 9; mem_lat = 1;
      set_in(1'b1, 2'b01, 1'b0);
      wait_bytes(5);
      set_in(1'b1, 2'b11, 1'b1);
      wait_bytes(12);
      check_seq("R9 window latched", 1'b0, 'h1B, 'h7F, 12);
      set_in(1'b1, 2'b00, 1'b0); repeat (4) @(negedge clk);
      chk("R9 still active under code 00", dump_active, 1);
      set_in(1'b0, 2'b00, 1'b0); repeat (4) @(negedge clk);
      chk("R8 no reload after code 00", rel_cnt, 0);
      chk("R7 idle after exit", dump_active, 0);

      summary();
      $finish;
   end
endmodule